// File: doc/BRIEF.md
# Raster Timing Generator with Composite Sync

This block produces the scan timing for a progressive VGA display whose colour path goes through a video DAC with a two-cycle conversion latency. It runs on the pixel clock and keeps two counters. The pixel counter walks each line from left to right. The line counter walks each frame from top to bottom. From these counters it derives registered outputs for the pixel-generation logic and the DAC:

- the pixel coordinates and an active-video flag;
- an active-low blank;
- an active-low composite sync, formed as the XOR of horizontal and vertical sync.

Blank and composite sync leave the block in the same register stage, so both reach the DAC together. The horizontal and vertical sync pins that go straight to the monitor connector pass through a further two-stage delay. Their edges therefore line up with the DAC's analog output. Their polarity is a parameter.

Each line is laid out as visible pixels, then front porch, then sync pulse, then back porch. Each frame is laid out the same way, counted in lines. All eight lengths are parameters.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high, every output is held as follows. `pixX` and `pixY` are 0. `active` is 0. `blankN` is 0. `csyncN` is 1. `hsyncOut` and `vsyncOut` sit at their inactive level, which is low when `SYNC_ACTIVE_HIGH`=1 and high when it is 0.
- R2: The outputs seen after the first rising edge with `rst` low describe the top-left visible pixel: `active`=1, `pixX`=0, `pixY`=0. After the k-th such edge, the registered outputs describe frame position p = k-1. Here p counts pixels row-major across the whole frame and wraps at HT*VT.
- R3: For a position p, the pixel index within the line is h = p mod HT, where HT = H_ACTIVE+H_FRONT+H_SYNC+H_BACK. The line is visible for h < H_ACTIVE. The horizontal sync pulse covers H_ACTIVE+H_FRONT <= h < H_ACTIVE+H_FRONT+H_SYNC.
- R4: The line index is v = (p div HT) mod VT, where VT = V_ACTIVE+V_FRONT+V_SYNC+V_BACK. It changes only when the pixel index wraps. Lines are visible for v < V_ACTIVE. Vertical sync covers V_ACTIVE+V_FRONT <= v < V_ACTIVE+V_FRONT+V_SYNC.
- R5: `active` is 1 exactly when both the line and the pixel are visible. While `active` is 1, `pixX`=h and `pixY`=v. While `active` is 0, both coordinates are 0.
- R6: `blankN` is low for every position outside the visible area and high inside it. It is updated in the same cycle as `csyncN`.
- R7: `csyncN` is low exactly when the horizontal sync pulse and the vertical sync pulse are not both present or both absent (XOR). As a result, it is inverted relative to horizontal sync during the vertical sync lines.
- R8: After the k-th edge with k >= 3, `hsyncOut` and `vsyncOut` show the horizontal and vertical sync state of position k-3. That is two clocks later than `csyncN`. A pin is high during its pulse when `SYNC_ACTIVE_HIGH`=1 and low during its pulse when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pixX | output | HCW | Pixel column during visible video, else 0 |
| pixY | output | VCW | Line row during visible video, else 0 |
| active | output | 1 | High for visible pixels |
| blankN | output | 1 | Active-low blank to the DAC |
| csyncN | output | 1 | Active-low composite sync (XOR) to the DAC green channel |
| hsyncOut | output | 1 | Connector horizontal sync, delayed two clocks, parameter polarity |
| vsyncOut | output | 1 | Connector vertical sync, delayed two clocks, parameter polarity |

## Verification
The hardest situation to reach is the stretch of lines where vertical sync is asserted. That is the only place where composite sync inverts and where the delayed connector pins must carry both pulses together. From the ports it is reached only by running through the whole frame. The bench therefore uses a tiny raster of 16 pixels by 8 lines and sweeps every position of several consecutive frames. At each position it compares all outputs against values computed from the position. A reset is then applied mid-frame and the sweep restarts, which shows that the next output is again the top-left pixel.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Region strobes passed from the counter control to the output datapath.
  typedef struct packed {
    logic hVisible;
    logic vVisible;
    logic hPulse;
    logic vPulse;
  } rasterStrobe_t;

endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  localparam int HT  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int VT  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int HCW = $clog2(HT),
  localparam int VCW = $clog2(VT)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [HCW-1:0] hCnt,
  output logic [VCW-1:0] vCnt,
  output rasterStrobe_t  strobe
);

  localparam int H_PULSE_START = H_ACTIVE + H_FRONT;
  localparam int H_PULSE_END   = H_PULSE_START + H_SYNC;
  localparam int V_PULSE_START = V_ACTIVE + V_FRONT;
  localparam int V_PULSE_END   = V_PULSE_START + V_SYNC;

  logic lineWrap;
  logic frameWrap;

  assign lineWrap  = (int'(hCnt) == HT - 1);
  assign frameWrap = (int'(vCnt) == VT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else begin
      if (lineWrap) begin
        hCnt <= '0;
        if (frameWrap) vCnt <= '0;
        else           vCnt <= vCnt + 1'b1;
      end else begin
        hCnt <= hCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.hVisible = (int'(hCnt) < H_ACTIVE);
    strobe.vVisible = (int'(vCnt) < V_ACTIVE);
    strobe.hPulse   = (int'(hCnt) >= H_PULSE_START) && (int'(hCnt) < H_PULSE_END);
    strobe.vPulse   = (int'(vCnt) >= V_PULSE_START) && (int'(vCnt) < V_PULSE_END);
  end

  // R3
  hcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(hCnt) < HT);

  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    !lineWrap |=> $stable(vCnt));

endmodule

// File: rtl/raster_datapath.sv
module raster_datapath
  import raster_pkg::*;
#(
  parameter int HCW              = 10,
  parameter int VCW              = 10,
  parameter bit SYNC_ACTIVE_HIGH = 1'b0,
  parameter int DAC_LATENCY      = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HCW-1:0] hCnt,
  input  logic [VCW-1:0] vCnt,
  input  rasterStrobe_t  strobe,
  output logic [HCW-1:0] pixX,
  output logic [VCW-1:0] pixY,
  output logic           active,
  output logic           blankN,
  output logic           csyncN,
  output logic           hsyncOut,
  output logic           vsyncOut
);

  logic visible;
  logic hsReg;
  logic vsReg;
  logic [DAC_LATENCY-1:0] hDly;
  logic [DAC_LATENCY-1:0] vDly;

  assign visible = strobe.hVisible & strobe.vVisible;

  // Stage aligned with the DAC codes: blank and composite sync share it.
  always_ff @(posedge clk) begin
    if (rst) begin
      pixX   <= '0;
      pixY   <= '0;
      active <= 1'b0;
      blankN <= 1'b0;
      csyncN <= 1'b1;
      hsReg  <= 1'b0;
      vsReg  <= 1'b0;
    end else begin
      pixX   <= visible ? hCnt : '0;
      pixY   <= visible ? vCnt : '0;
      active <= visible;
      blankN <= visible;
      csyncN <= ~(strobe.hPulse ^ strobe.vPulse);
      hsReg  <= strobe.hPulse;
      vsReg  <= strobe.vPulse;
    end
  end

  // Delay line matching the DAC conversion latency for the connector pins.
  generate
    if (DAC_LATENCY == 1) begin : g_dly1
      always_ff @(posedge clk) begin
        if (rst) begin
          hDly <= '0;
          vDly <= '0;
        end else begin
          hDly <= hsReg;
          vDly <= vsReg;
        end
      end
    end else begin : g_dlyN
      always_ff @(posedge clk) begin
        if (rst) begin
          hDly <= '0;
          vDly <= '0;
        end else begin
          hDly <= {hDly[DAC_LATENCY-2:0], hsReg};
          vDly <= {vDly[DAC_LATENCY-2:0], vsReg};
        end
      end
    end
  endgenerate

  generate
    if (SYNC_ACTIVE_HIGH) begin : g_polHigh
      assign hsyncOut = hDly[DAC_LATENCY-1];
      assign vsyncOut = vDly[DAC_LATENCY-1];
    end else begin : g_polLow
      assign hsyncOut = ~hDly[DAC_LATENCY-1];
      assign vsyncOut = ~vDly[DAC_LATENCY-1];
    end
  endgenerate

  // R5
  coord_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> (pixX == '0 && pixY == '0));

  // R7
  csync_xor_chk: assert property (@(posedge clk) disable iff (rst)
    csyncN == !(hsReg ^ vsReg));

  // R6
  blank_match_chk: assert property (@(posedge clk) disable iff (rst)
    blankN == active);

  generate
    if (DAC_LATENCY == 2) begin : g_lagChk
      // R8
      connector_lag_chk: assert property (@(posedge clk) disable iff (rst)
        (hDly[1] == $past(hsReg, 2)) && (vDly[1] == $past(vsReg, 2)));
    end
  endgenerate

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int H_ACTIVE         = 640,
  parameter int H_FRONT          = 16,
  parameter int H_SYNC           = 96,
  parameter int H_BACK           = 48,
  parameter int V_ACTIVE         = 480,
  parameter int V_FRONT          = 10,
  parameter int V_SYNC           = 2,
  parameter int V_BACK           = 33,
  parameter bit SYNC_ACTIVE_HIGH = 1'b0,
  localparam int HT  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int VT  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int HCW = $clog2(HT),
  localparam int VCW = $clog2(VT)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [HCW-1:0] pixX,
  output logic [VCW-1:0] pixY,
  output logic           active,
  output logic           blankN,
  output logic           csyncN,
  output logic           hsyncOut,
  output logic           vsyncOut
);

  localparam int DAC_LATENCY = 2;

  logic [HCW-1:0] hCnt;
  logic [VCW-1:0] vCnt;
  rasterStrobe_t  strobe;

  raster_ctrl #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .hCnt   (hCnt),
    .vCnt   (vCnt),
    .strobe (strobe)
  );

  raster_datapath #(
    .HCW(HCW), .VCW(VCW),
    .SYNC_ACTIVE_HIGH(SYNC_ACTIVE_HIGH),
    .DAC_LATENCY(DAC_LATENCY)
  ) uData (
    .clk      (clk),
    .rst      (rst),
    .hCnt     (hCnt),
    .vCnt     (vCnt),
    .strobe   (strobe),
    .pixX     (pixX),
    .pixY     (pixY),
    .active   (active),
    .blankN   (blankN),
    .csyncN   (csyncN),
    .hsyncOut (hsyncOut),
    .vsyncOut (vsyncOut)
  );

endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;

  localparam int HA = 8, HF = 2, HS = 3, HB = 3;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int HCW = $clog2(HT);
  localparam int VCW = $clog2(VT);
  localparam bit POL = 1'b0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HCW-1:0] pixX;
  logic [VCW-1:0] pixY;
  logic active, blankN, csyncN, hsyncOut, vsyncOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  raster_timing_gen #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .SYNC_ACTIVE_HIGH(POL)
  ) u0 (
    .clk(clk), .rst(rst), .pixX(pixX), .pixY(pixY), .active(active),
    .blankN(blankN), .csyncN(csyncN), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  function automatic bit hPulseAt(int p);
    int h = p % HT;
    return (h >= HA + HF) && (h < HA + HF + HS);
  endfunction

  function automatic bit vPulseAt(int p);
    int v = (p / HT) % VT;
    return (v >= VA + VF) && (v < VA + VF + VS);
  endfunction

  function automatic int pinLevel(bit pulse);
    return POL ? int'(pulse) : int'(!pulse);
  endfunction

  task automatic checkResetState();
    check("R1 pixX", int'(pixX), 0);
    check("R1 pixY", int'(pixY), 0);
    check("R1 active", int'(active), 0);
    check("R1 blankN", int'(blankN), 0);
    check("R1 csyncN", int'(csyncN), 1);
    check("R1 hsyncOut", int'(hsyncOut), pinLevel(1'b0));
    check("R1 vsyncOut", int'(vsyncOut), pinLevel(1'b0));
  endtask

  // Sweep n edges after reset release; samples at the falling edge.
  task automatic sweep(input int n);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      begin
        int p = (k - 1) % (HT * VT);
        int h = p % HT;
        int v = p / HT;
        bit vis = (h < HA) && (v < VA);
        bit hp = hPulseAt(p);
        bit vp = vPulseAt(p);
        if (k == 1) begin
          check("R2 first active", int'(active), 1);
          check("R2 first pixX", int'(pixX), 0);
          check("R2 first pixY", int'(pixY), 0);
        end
        check("R3 active", int'(active), int'(vis));
        check("R5 pixX", int'(pixX), vis ? h : 0);
        check("R4 R5 pixY", int'(pixY), vis ? v : 0);
        check("R6 blankN", int'(blankN), int'(vis));
        check("R7 csyncN", int'(csyncN), int'(!(hp ^ vp)));
        if (k >= 3) begin
          check("R8 hsyncOut", int'(hsyncOut), pinLevel(hPulseAt(k - 3)));
          check("R8 vsyncOut", int'(vsyncOut), pinLevel(vPulseAt(k - 3)));
        end else begin
          check("R8 hsyncOut idle", int'(hsyncOut), pinLevel(1'b0));
          check("R8 vsyncOut idle", int'(vsyncOut), pinLevel(1'b0));
        end
      end
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checkResetState();
    rst = 1'b0;
    sweep(3 * HT * VT + 5);
    // Reset in the middle of a frame, then a fresh sweep.
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    checkResetState();
    rst = 1'b0;
    sweep(2 * HT * VT);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule